// File: doc/BRIEF.md
# Clock Stop Gating Controller

This block sits between a set of free-running source clocks and the output pins of a clock generator. It passes each source clock to one or more outputs, and it can stop or restart each output on request. The requests come from two active-low stop pins, one for the PCI-class outputs and one for the CPU differential pairs, and from a bank of static configuration bits. Every output has its own gate cell. The cell brings the request into that output's clock domain and changes the gate only at a falling edge of the source. As a result, an output never shows a shortened pulse.

The PCI-class outputs have three kinds of stop behaviour. The plain PCI outputs always obey the PCI stop. The selectable outputs each choose between obeying the stop and running freely. The 66 MHz and 48 MHz outputs ignore the stop and follow only their enable bits. The CPU pairs have a per-pair free-run choice. A shared bit picks the stopped state: the true leg is held high with the complement low, or both legs are released to high impedance. Software-visible registers are out of scope. The configuration bits arrive as plain inputs.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n_i` is low, every gated output and both legs of every CPU pair are low, and every `cpu_oe_o` bit is high.
- R2: The PCI stop condition is active when `pci_stop_n_i` is low or `cfg_pci_stop_n_i` is low, and is inactive only when both are high.
- R3: While the PCI stop condition is active, each `pci_o` bit is low. While it is inactive, each `pci_o` bit whose `cfg_pci_en_i` bit is 1 follows `clk_pci_i`.
- R4: A `pcisel_o` bit whose `cfg_sel_obey_i` bit is 0 keeps running while the PCI stop is active. When that bit is 1, the output stops low like a `pci_o` bit.
- R5: An enable bit of 0 (`cfg_pci_en_i`, `cfg_sel_en_i`, `cfg_66_en_i`, `cfg_48_en_i`) holds its output low, whatever the stop state. The 66 MHz and 48 MHz outputs ignore both stop pins.
- R6: After a request changes, the output changes at the first falling edge of its own source clock that follows two rising edges of that source clock. It does not change at any other time.
- R7: A gated output is high only while its source is high. Every high pulse lasts one full source high phase, and every low interval lasts at least one full source low phase.
- R8: While `cpu_stop_n_i` is low, a CPU pair whose `cfg_cpu_freerun_i` bit is 0 enters its stopped state. A pair whose bit is 1 keeps running.
- R9: In the stopped state with `cfg_cpu_tri_i` = 0, the true leg is high, the complement is low and `cpu_oe_o` is high. With `cfg_cpu_tri_i` = 1, both legs are low and `cpu_oe_o` is low.
- R10: A CPU pair whose `cfg_cpu_en_i` bit is 0 drives both legs low with `cpu_oe_o` high, whatever the stop pin.
- R11: A running CPU pair drives the true leg equal to `clk_cpu_i` and the complement leg to its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Source clock for the CPU pairs |
| clk_pci_i | input | 1 | Source clock for the PCI and selectable outputs |
| clk_66_i | input | 1 | Source clock for the 66 MHz outputs |
| clk_48_i | input | 1 | Source clock for the 48 MHz outputs |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pci_stop_n_i | input | 1 | PCI stop pin, active low |
| cfg_pci_stop_n_i | input | 1 | Configuration stop bit, active low, combined with the pin |
| cpu_stop_n_i | input | 1 | CPU stop pin, active low |
| cfg_pci_en_i | input | NUM_PCI | Enable per PCI output |
| cfg_sel_en_i | input | NUM_SEL | Enable per selectable output |
| cfg_sel_obey_i | input | NUM_SEL | 1 = selectable output obeys PCI stop |
| cfg_66_en_i | input | NUM_66 | Enable per 66 MHz output |
| cfg_48_en_i | input | NUM_48 | Enable per 48 MHz output |
| cfg_cpu_en_i | input | NUM_CPU | Enable per CPU pair |
| cfg_cpu_freerun_i | input | NUM_CPU | 1 = CPU pair ignores CPU stop |
| cfg_cpu_tri_i | input | 1 | Stopped CPU state: 0 = hold high, 1 = float |
| pci_o | output | NUM_PCI | Gated PCI clocks |
| pcisel_o | output | NUM_SEL | Gated selectable PCI clocks |
| clk66_o | output | NUM_66 | Gated 66 MHz clocks |
| clk48_o | output | NUM_48 | Gated 48 MHz clocks |
| cpu_t_o | output | NUM_CPU | CPU pair true legs |
| cpu_c_o | output | NUM_CPU | CPU pair complement legs |
| cpu_oe_o | output | NUM_CPU | CPU pair drive enable, 0 = high impedance |

## Verification
Two events can fall on the same source edge: a change of the stop condition and a change of an enable. The bench provokes this in two places. It asserts the PCI stop pin in the same cycle that it clears a PCI enable and the enable of a free-running selectable output. It also releases the CPU stop in the same cycle that it flips the tri-state choice and re-enables a pair. A behavioural model with a queue per clock domain predicts every output at every bench clock. The model places each request at the falling edge that follows two rising source edges. Directed samples taken mid-phase, together with pulse-width monitors, judge the latency and the absence of shortened pulses.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   localparam int MIN_SYNC_STAGES = 2;

   typedef enum logic [1:0] {
      CPU_OFF   = 2'b00,
      CPU_RUN   = 2'b01,
      CPU_HOLD  = 2'b10,
      CPU_FLOAT = 2'b11
   } cpu_state_e;

   function automatic cpu_state_e cpu_next(input logic en,
                                           input logic stop,
                                           input logic freerun,
                                           input logic tri_sel);
      if (!en)
         return CPU_OFF;
      else if (stop && !freerun)
         return tri_sel ? CPU_FLOAT : CPU_HOLD;
      else
         return CPU_RUN;
   endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import clkstop_pkg::*;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
         $error("cg_sync: STAGES below minimum");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cg_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell #(
   parameter int STAGES    = 2,
   parameter bit USE_LATCH = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic en_i,
   input  logic obey_i,
   input  logic stop_i,
   output logic clk_o
);
   localparam int REQ_W = 3;

   logic [REQ_W-1:0] req_s;
   logic             run_req;
   logic             run_q;

   cg_sync #(.WIDTH(REQ_W), .STAGES(STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     ({en_i, obey_i, stop_i}),
      .q_o     (req_s)
   );

   assign run_req = req_s[2] & ~(req_s[1] & req_s[0]);

   generate
      if (USE_LATCH) begin : g_latch
         always_latch begin
            if (!rst_n_i)    run_q = 1'b0;
            else if (!clk_i) run_q = run_req;
         end
      end else begin : g_negflop
         always_ff @(negedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) run_q <= 1'b0;
            else          run_q <= run_req;
         end
      end
   endgenerate

   assign clk_o = clk_i & run_q;

   AST_GATE_STOPS_AT_LOW: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      !run_req |=> !clk_o); // R6
   AST_GATE_RUNS_AT_LOW: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      run_req |=> clk_o); // R6
   AST_GATE_QUIET_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !clk_o); // R7

endmodule

// File: rtl/cg_cpu_pair.sv
module cg_cpu_pair #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic en_i,
   input  logic stop_i,
   input  logic freerun_i,
   input  logic tri_i,
   output logic t_o,
   output logic c_o,
   output logic oe_o
);
   import clkstop_pkg::*;

   localparam int REQ_W = 4;

   logic [REQ_W-1:0] req_s;
   cpu_state_e       state_d;
   cpu_state_e       state_q;

   cg_sync #(.WIDTH(REQ_W), .STAGES(STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     ({en_i, stop_i, freerun_i, tri_i}),
      .q_o     (req_s)
   );

   assign state_d = cpu_next(req_s[3], req_s[2], req_s[1], req_s[0]);

   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) state_q <= CPU_OFF;
      else          state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         CPU_RUN:   begin t_o = clk_i; c_o = ~clk_i; oe_o = 1'b1; end
         CPU_HOLD:  begin t_o = 1'b1;  c_o = 1'b0;   oe_o = 1'b1; end
         CPU_FLOAT: begin t_o = 1'b0;  c_o = 1'b0;   oe_o = 1'b0; end
         default:   begin t_o = 1'b0;  c_o = 1'b0;   oe_o = 1'b1; end
      endcase
   end

   AST_CPU_HOLD_HIGH: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      (state_d == CPU_HOLD) |=> (t_o && !c_o && oe_o)); // R9
   AST_CPU_FLOAT_OFF: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      (state_d == CPU_FLOAT) |=> (!t_o && !c_o && !oe_o)); // R9
   AST_CPU_DISABLED_LOW: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      (state_d == CPU_OFF) |=> (!t_o && !c_o && oe_o)); // R10
   AST_CPU_RUN_COMPL: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      (state_d == CPU_RUN) |=> (t_o && !c_o && oe_o)); // R11

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
   parameter int NUM_PCI     = 6,
   parameter int NUM_SEL     = 3,
   parameter int NUM_66      = 6,
   parameter int NUM_48      = 2,
   parameter int NUM_CPU     = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_LATCH   = 1'b0
) (
   input  logic               clk_cpu_i,
   input  logic               clk_pci_i,
   input  logic               clk_66_i,
   input  logic               clk_48_i,
   input  logic               rst_n_i,
   input  logic               pci_stop_n_i,
   input  logic               cfg_pci_stop_n_i,
   input  logic               cpu_stop_n_i,
   input  logic [NUM_PCI-1:0] cfg_pci_en_i,
   input  logic [NUM_SEL-1:0] cfg_sel_en_i,
   input  logic [NUM_SEL-1:0] cfg_sel_obey_i,
   input  logic [NUM_66-1:0]  cfg_66_en_i,
   input  logic [NUM_48-1:0]  cfg_48_en_i,
   input  logic [NUM_CPU-1:0] cfg_cpu_en_i,
   input  logic [NUM_CPU-1:0] cfg_cpu_freerun_i,
   input  logic               cfg_cpu_tri_i,
   output logic [NUM_PCI-1:0] pci_o,
   output logic [NUM_SEL-1:0] pcisel_o,
   output logic [NUM_66-1:0]  clk66_o,
   output logic [NUM_48-1:0]  clk48_o,
   output logic [NUM_CPU-1:0] cpu_t_o,
   output logic [NUM_CPU-1:0] cpu_c_o,
   output logic [NUM_CPU-1:0] cpu_oe_o
);
   import clkstop_pkg::*;

   generate
      if (NUM_PCI < 1 || NUM_SEL < 1 || NUM_66 < 1 || NUM_48 < 1 || NUM_CPU < 1) begin : g_bad_count
         $error("clkstop_ctrl: every output group needs at least one member");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("clkstop_ctrl: SYNC_STAGES too small");
      end
   endgenerate

   logic pci_stop;
   logic cpu_stop;

   assign pci_stop = ~(pci_stop_n_i & cfg_pci_stop_n_i);
   assign cpu_stop = ~cpu_stop_n_i;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PCI; gi++) begin : g_pci
         cg_gate_cell #(.STAGES(SYNC_STAGES), .USE_LATCH(USE_LATCH)) u_cell (
            .clk_i   (clk_pci_i),
            .rst_n_i (rst_n_i),
            .en_i    (cfg_pci_en_i[gi]),
            .obey_i  (1'b1),
            .stop_i  (pci_stop),
            .clk_o   (pci_o[gi])
         );
      end
      for (gi = 0; gi < NUM_SEL; gi++) begin : g_sel
         cg_gate_cell #(.STAGES(SYNC_STAGES), .USE_LATCH(USE_LATCH)) u_cell (
            .clk_i   (clk_pci_i),
            .rst_n_i (rst_n_i),
            .en_i    (cfg_sel_en_i[gi]),
            .obey_i  (cfg_sel_obey_i[gi]),
            .stop_i  (pci_stop),
            .clk_o   (pcisel_o[gi])
         );
      end
      for (gi = 0; gi < NUM_66; gi++) begin : g_66
         cg_gate_cell #(.STAGES(SYNC_STAGES), .USE_LATCH(USE_LATCH)) u_cell (
            .clk_i   (clk_66_i),
            .rst_n_i (rst_n_i),
            .en_i    (cfg_66_en_i[gi]),
            .obey_i  (1'b0),
            .stop_i  (1'b0),
            .clk_o   (clk66_o[gi])
         );
      end
      for (gi = 0; gi < NUM_48; gi++) begin : g_48
         cg_gate_cell #(.STAGES(SYNC_STAGES), .USE_LATCH(USE_LATCH)) u_cell (
            .clk_i   (clk_48_i),
            .rst_n_i (rst_n_i),
            .en_i    (cfg_48_en_i[gi]),
            .obey_i  (1'b0),
            .stop_i  (1'b0),
            .clk_o   (clk48_o[gi])
         );
      end
      for (gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
         cg_cpu_pair #(.STAGES(SYNC_STAGES)) u_pair (
            .clk_i     (clk_cpu_i),
            .rst_n_i   (rst_n_i),
            .en_i      (cfg_cpu_en_i[gi]),
            .stop_i    (cpu_stop),
            .freerun_i (cfg_cpu_freerun_i[gi]),
            .tri_i     (cfg_cpu_tri_i),
            .t_o       (cpu_t_o[gi]),
            .c_o       (cpu_c_o[gi]),
            .oe_o      (cpu_oe_o[gi])
         );
      end
   endgenerate

   AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk_pci_i)
      !rst_n_i |-> (pci_o == '0 && pcisel_o == '0 && cpu_t_o == '0 && cpu_oe_o == '1)); // R1

endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;

   localparam int NP = 6;
   localparam int NS = 3;
   localparam int N66 = 6;
   localparam int N48 = 2;
   localparam int NC = 2;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic src_cpu = 1'b0, src_pci = 1'b0, src_66 = 1'b0, src_48 = 1'b0;
   logic rst_n = 1'b0;
   logic pci_stop_n = 1'b1, pci_stop_reg_n = 1'b1, cpu_stop_n = 1'b1, cpu_tri = 1'b0;
   logic [NP-1:0]  pci_en  = '1;
   logic [NS-1:0]  sel_en  = '1;
   logic [NS-1:0]  sel_obey = '1;
   logic [N66-1:0] c66_en  = '1;
   logic [N48-1:0] c48_en  = '1;
   logic [NC-1:0]  cpu_en  = '1;
   logic [NC-1:0]  cpu_fr  = '0;

   logic [NP-1:0]  pci_o;
   logic [NS-1:0]  pcisel_o;
   logic [N66-1:0] clk66_o;
   logic [N48-1:0] clk48_o;
   logic [NC-1:0]  cpu_t_o, cpu_c_o, cpu_oe_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   clkstop_ctrl uut (
      .clk_cpu_i         (src_cpu),
      .clk_pci_i         (src_pci),
      .clk_66_i          (src_66),
      .clk_48_i          (src_48),
      .rst_n_i           (rst_n),
      .pci_stop_n_i      (pci_stop_n),
      .cfg_pci_stop_n_i  (pci_stop_reg_n),
      .cpu_stop_n_i      (cpu_stop_n),
      .cfg_pci_en_i      (pci_en),
      .cfg_sel_en_i      (sel_en),
      .cfg_sel_obey_i    (sel_obey),
      .cfg_66_en_i       (c66_en),
      .cfg_48_en_i       (c48_en),
      .cfg_cpu_en_i      (cpu_en),
      .cfg_cpu_freerun_i (cpu_fr),
      .cfg_cpu_tri_i     (cpu_tri),
      .pci_o             (pci_o),
      .pcisel_o          (pcisel_o),
      .clk66_o           (clk66_o),
      .clk48_o           (clk48_o),
      .cpu_t_o           (cpu_t_o),
      .cpu_c_o           (cpu_c_o),
      .cpu_oe_o          (cpu_oe_o)
   );

   // 125 MHz bench clock; source edges fall on odd ns, bench edges on even ns
   initial forever #4 clk = ~clk;
   initial begin #1; forever #4  src_cpu = ~src_cpu; end
   initial begin #3; forever #8  src_66  = ~src_66;  end
   initial begin #5; forever #16 src_pci = ~src_pci; end
   initial begin #7; forever #10 src_48  = ~src_48;  end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic logic [NP+NS-1:0] pci_req();
      logic stop;
      logic [NP+NS-1:0] r;
      stop = ~(pci_stop_n & pci_stop_reg_n);        // R2
      r[NP-1:0] = pci_en & {NP{~stop}};
      r[NP+NS-1:NP] = sel_en & ~(sel_obey & {NS{stop}});
      return r;
   endfunction

   // bench encoding: 0 disabled, 1 running, 2 held high, 3 floating
   function automatic logic [2*NC-1:0] cpu_req();
      logic [2*NC-1:0] r;
      for (int i = 0; i < NC; i++) begin
         if (!cpu_en[i])                r[2*i +: 2] = 2'd0;
         else if (!cpu_stop_n && !cpu_fr[i]) r[2*i +: 2] = cpu_tri ? 2'd3 : 2'd2;
         else                           r[2*i +: 2] = 2'd1;
      end
      return r;
   endfunction

   logic [NP+NS-1:0] q_pci[$];
   logic [N66-1:0]   q_66[$];
   logic [N48-1:0]   q_48[$];
   logic [2*NC-1:0]  q_cpu[$];
   logic [NP+NS-1:0] m_pci = '0;
   logic [N66-1:0]   m_66 = '0;
   logic [N48-1:0]   m_48 = '0;
   logic [2*NC-1:0]  m_cpu = '0;

   always @(posedge src_pci or negedge rst_n)
      if (!rst_n) q_pci.delete();
      else begin q_pci.push_back(pci_req()); if (q_pci.size() > SYNC) void'(q_pci.pop_front()); end
   always @(posedge src_66 or negedge rst_n)
      if (!rst_n) q_66.delete();
      else begin q_66.push_back(c66_en); if (q_66.size() > SYNC) void'(q_66.pop_front()); end
   always @(posedge src_48 or negedge rst_n)
      if (!rst_n) q_48.delete();
      else begin q_48.push_back(c48_en); if (q_48.size() > SYNC) void'(q_48.pop_front()); end
   always @(posedge src_cpu or negedge rst_n)
      if (!rst_n) q_cpu.delete();
      else begin q_cpu.push_back(cpu_req()); if (q_cpu.size() > SYNC) void'(q_cpu.pop_front()); end

   always @(negedge src_pci or negedge rst_n)
      if (!rst_n) m_pci = '0; else m_pci = (q_pci.size() == SYNC) ? q_pci[0] : '0;
   always @(negedge src_66 or negedge rst_n)
      if (!rst_n) m_66 = '0; else m_66 = (q_66.size() == SYNC) ? q_66[0] : '0;
   always @(negedge src_48 or negedge rst_n)
      if (!rst_n) m_48 = '0; else m_48 = (q_48.size() == SYNC) ? q_48[0] : '0;
   always @(negedge src_cpu or negedge rst_n)
      if (!rst_n) m_cpu = '0; else m_cpu = (q_cpu.size() == SYNC) ? q_cpu[0] : '0;

   // compare every bench clock, away from all edges
   always @(negedge clk) begin
      logic [NP+NS-1:0] e_pci;
      logic [3*NC-1:0]  e_cpu, a_cpu;
      if (!done) begin
         e_pci = src_pci ? m_pci : '0;
         chk(pci_o === e_pci[NP-1:0], "R3 pci model", pci_o, e_pci[NP-1:0]);
         chk(pcisel_o === e_pci[NP+NS-1:NP], "R4 sel model", pcisel_o, e_pci[NP+NS-1:NP]);
         chk(clk66_o === (src_66 ? m_66 : '0), "R5 66 model", clk66_o, src_66 ? m_66 : '0);
         chk(clk48_o === (src_48 ? m_48 : '0), "R5 48 model", clk48_o, src_48 ? m_48 : '0);
         for (int i = 0; i < NC; i++) begin
            case (m_cpu[2*i +: 2])
               2'd1:    e_cpu[3*i +: 3] = {src_cpu, ~src_cpu, 1'b1};
               2'd2:    e_cpu[3*i +: 3] = 3'b101;
               2'd3:    e_cpu[3*i +: 3] = 3'b000;
               default: e_cpu[3*i +: 3] = 3'b001;
            endcase
            a_cpu[3*i +: 3] = {cpu_t_o[i], cpu_c_o[i], cpu_oe_o[i]};
         end
         chk(a_cpu === e_cpu, "R8 cpu model", a_cpu, e_cpu);
      end
   end

   // pulse-width monitors (R7)
   realtime p_rise = 0.0, p_fall = 0.0, u_rise = 0.0;
   bit p_seen_r = 0, p_seen_f = 0, u_seen_r = 0;
   always @(posedge pci_o[0]) begin
      if (p_seen_f) chk(($realtime - p_fall) >= 16.0, "R7 pci low width", $rtoi($realtime - p_fall), 16);
      p_rise = $realtime; p_seen_r = 1;
   end
   always @(negedge pci_o[0]) if (rst_n) begin
      if (p_seen_r) chk(($realtime - p_rise) == 16.0, "R7 pci high width", $rtoi($realtime - p_rise), 16);
      p_fall = $realtime; p_seen_f = 1;
   end
   always @(posedge clk48_o[0]) begin u_rise = $realtime; u_seen_r = 1; end
   always @(negedge clk48_o[0]) if (rst_n && u_seen_r)
      chk(($realtime - u_rise) == 10.0, "R7 48 high width", $rtoi($realtime - u_rise), 10);

   task automatic settle(); repeat (16) @(posedge clk); endtask
   task automatic pci_hi(); @(posedge src_pci); #2; endtask
   task automatic cpu_hi(); @(posedge src_cpu); #2; endtask
   task automatic cpu_lo(); @(negedge src_cpu); #2; endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pci_o == '0 && pcisel_o == '0, "R1 reset pci", {pcisel_o, pci_o}, 0);
      chk(clk66_o == '0 && clk48_o == '0, "R1 reset 66/48", {clk66_o, clk48_o}, 0);
      chk(cpu_t_o == '0 && cpu_c_o == '0 && cpu_oe_o == '1, "R1 reset cpu",
          {cpu_t_o, cpu_c_o, cpu_oe_o}, 6'h03);
      @(posedge clk); rst_n = 1'b1;
      settle();

      pci_hi();
      chk(pci_o == '1, "R3 running", pci_o, 6'h3f);

      // R6 latency: stop set between source edges
      @(posedge clk); pci_stop_n = 1'b0;
      pci_hi(); chk(pci_o[0] == 1'b1, "R6 after first rise", pci_o[0], 1);
      pci_hi(); chk(pci_o[0] == 1'b1, "R6 after second rise", pci_o[0], 1);
      pci_hi(); chk(pci_o == '0, "R6 stopped after third rise", pci_o, 0);
      chk(pcisel_o == '0, "R4 obeying outputs stop", pcisel_o, 0);

      @(posedge clk); sel_obey = 3'b010;
      settle(); pci_hi();
      chk(pcisel_o == 3'b101, "R4 free-running ignore stop", pcisel_o, 3'b101);

      @(posedge clk); pci_stop_n = 1'b1; pci_stop_reg_n = 1'b0;
      settle(); pci_hi();
      chk(pci_o == '0, "R2 register bit alone stops", pci_o, 0);
      @(posedge clk); pci_stop_reg_n = 1'b1;
      settle(); pci_hi();
      chk(pci_o == '1, "R2 both released", pci_o, 6'h3f);

      // same cycle: stop pin and enables change together
      @(posedge clk); pci_stop_n = 1'b0; pci_en[2] = 1'b0; sel_en = 3'b110;
      settle(); pci_hi();
      chk(pcisel_o == 3'b100, "R5 disabled free output low", pcisel_o, 3'b100);
      @(posedge clk); pci_stop_n = 1'b1;
      settle(); pci_hi();
      chk(pci_o == 6'b111011, "R5 pci enable", pci_o, 6'b111011);
      chk(pcisel_o == 3'b110, "R5 sel enable", pcisel_o, 3'b110);

      @(posedge clk); c66_en = 6'b101010; c48_en = 2'b01; pci_stop_n = 1'b0; cpu_stop_n = 1'b0;
      cpu_fr = 2'b11;
      settle();
      @(posedge src_66); #2;
      chk(clk66_o == 6'b101010, "R5 66 enables ignore stop", clk66_o, 6'b101010);
      @(posedge src_48); #2;
      chk(clk48_o == 2'b01, "R5 48 enables ignore stop", clk48_o, 2'b01);

      @(posedge clk); pci_stop_n = 1'b1; cpu_fr = 2'b10;
      settle(); cpu_hi();
      chk(cpu_t_o == 2'b11 && cpu_c_o == 2'b00 && cpu_oe_o == 2'b11, "R9 hold high",
          {cpu_t_o, cpu_c_o, cpu_oe_o}, 6'b110011);
      cpu_lo();
      chk(cpu_t_o == 2'b01 && cpu_c_o == 2'b10, "R8 free pair runs, R11 complement",
          {cpu_t_o, cpu_c_o}, 4'b0110);

      @(posedge clk); cpu_tri = 1'b1;
      settle(); cpu_hi();
      chk(cpu_oe_o == 2'b10 && cpu_t_o == 2'b10 && cpu_c_o == 2'b00, "R9 float",
          {cpu_t_o, cpu_c_o, cpu_oe_o}, 6'b100010);

      @(posedge clk); cpu_en = 2'b01;
      settle(); cpu_hi();
      chk(cpu_t_o == 2'b00 && cpu_c_o == 2'b00 && cpu_oe_o == 2'b10, "R10 disabled pair",
          {cpu_t_o, cpu_c_o, cpu_oe_o}, 6'b000010);

      // same cycle: stop release, tri choice and enable change together
      @(posedge clk); cpu_stop_n = 1'b1; cpu_tri = 1'b0; cpu_en = 2'b11;
      settle(); cpu_hi();
      chk(cpu_t_o == 2'b11 && cpu_c_o == 2'b00 && cpu_oe_o == 2'b11, "R11 running high",
          {cpu_t_o, cpu_c_o, cpu_oe_o}, 6'b110011);
      cpu_lo();
      chk(cpu_t_o == 2'b00 && cpu_c_o == 2'b11, "R11 running low", {cpu_t_o, cpu_c_o}, 4'b0011);

      settle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog (R1..) actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule